// File: doc/BRIEF.md
# Sleep-to-Wake Sample Rate Controller

This block decides how fast a three-axis sensor front end takes samples and issues a one-cycle sample strobe derived from a fixed base clock. Three configuration fields set the rate. A 3-bit power-mode field selects power-down, full-rate operation or one of five slow low-power rates. A 2-bit data-rate field selects one of four full rates. A 2-bit sleep field can override both of them.

With the sleep field armed, the block samples at a slow rate and waits for the interrupt generator to report an event. When that event arrives, the block rewrites its own sleep field to the "woken" code and moves to the full data rate in the same step. The power-mode field is left untouched, and it stays without effect until software clears the sleep field. A status output reports the resulting operating mode. A separate flag shows power-down, during which no strobes are issued, so downstream output registers keep their last sample.

The strobe period is computed from the parameter `BASE_HZ`, the base clock frequency in hertz. A rate of R hertz gives a period of floor(2·BASE_HZ / 2R) base cycles, with a minimum of 1. The configuration write ports are plain single-cycle strobes with no back-pressure: a write is always taken on the clock edge where its strobe is high.

Top module: `s2w_rate_ctrl`

## Requirements
- R1: After reset, pm_q=000, dr_q=00 and slp_q=00, mode_o=00 (power-down), pwr_down=1, and no sample_tick is issued.
- R2: With the sleep field at 00 and power-mode 001, the strobe period follows the data-rate code: 00, 01, 10 and 11 give 50, 100, 400 and 1000 Hz. mode_o reads 01 (full rate).
- R3: With the sleep field at 00, power-mode codes 010, 011, 100, 101 and 110 give 0.5, 1, 2, 5 and 10 Hz, and mode_o reads 10 (low power).
- R4: Power-mode codes 000 and 111 (the latter undefined) mean power-down: pwr_down=1, mode_o=00, and sample_tick stays low from the second cycle on.
- R5: Sleep field 11 arms the feature, and mode_o reads 11. The sleep rate comes from the power-mode field when that field holds a low-power code, and is 0.5 Hz otherwise. A power-mode of 000 does not power the block down while it is armed.
- R6: When irq_evt is high while the sleep field is 11, slp_q reads 01 on the next cycle, pm_q is unchanged, and the strobe moves to the data-rate frequency.
- R7: irq_evt has no effect while the sleep field is not 11.
- R8: Sleep field 01, whether written or reached through R6, runs at the data-rate frequency with mode_o=01, whatever the power-mode field holds, 000 included.
- R9: The reserved sleep code 10 behaves exactly as 00: the power-mode field decides.
- R10: Every change of the selected rate restarts the divider. After the clock edge that takes a write, sample_tick stays low for D edges and rises after edge D+1, where D is the new period. The strobe is never high in the cycle that follows a rate change.
- R11: A sleep-field write on the same edge as an event wins over the automatic change to 01.
- R12: Writing 11 again after a wake re-arms the feature, and writing 00 returns the block to the rate chosen by the power-mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, BASE_HZ hertz |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for power-mode and data-rate fields |
| cfg_pm | input | 3 | Power-mode value to write |
| cfg_dr | input | 2 | Data-rate value to write |
| slp_wr | input | 1 | Write strobe for the sleep field |
| slp_val | input | 2 | Sleep-field value to write |
| irq_evt | input | 1 | Event from the interrupt generator |
| sample_tick | output | 1 | One-cycle sample strobe |
| pm_q | output | 3 | Power-mode field readback |
| dr_q | output | 2 | Data-rate field readback |
| slp_q | output | 2 | Sleep-field readback |
| mode_o | output | 2 | 00 power-down, 01 full rate, 10 low power, 11 armed |
| pwr_down | output | 1 | High while in power-down |

## Verification
A wrong rate decode shows as a strobe period that differs from the expected base-cycle count. The bench measures that count between two consecutive strobes, so a decode fault shows within two periods at most. A fault in the sleep-field update shows on slp_q and mode_o one cycle after the event or the write. A divider that fails to restart shows either a strobe inside the D-edge quiet window after a rate change or a late first strobe, within D+1 cycles of the write.

// File: rtl/s2w_pkg.sv
package s2w_pkg;

  typedef enum logic [1:0] {
    MD_DOWN   = 2'b00,
    MD_FULL   = 2'b01,
    MD_LOWPWR = 2'b10,
    MD_ARMED  = 2'b11
  } mode_e;

  localparam logic [1:0] SLP_OFF  = 2'b00;
  localparam logic [1:0] SLP_WOKE = 2'b01;
  localparam logic [1:0] SLP_RSVD = 2'b10;
  localparam logic [1:0] SLP_ARM  = 2'b11;

  localparam int RATE_W    = 4;
  localparam int RATE_SLOTS = 2 ** RATE_W;
  typedef logic [RATE_W-1:0] rate_t;

  // rate index: 0 = stopped, 1..5 slow rates, 6..9 full rates
  localparam rate_t RT_OFF    = 4'd0;
  localparam rate_t RT_LP_MIN = 4'd1;
  localparam rate_t RT_FULL0  = 4'd6;

  // twice the sampling frequency, so the half-hertz rate stays integral
  function automatic int unsigned rate_x2(input rate_t r);
    case (r)
      4'd1:    return 1;
      4'd2:    return 2;
      4'd3:    return 4;
      4'd4:    return 10;
      4'd5:    return 20;
      4'd6:    return 100;
      4'd7:    return 200;
      4'd8:    return 800;
      4'd9:    return 2000;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned rate_div(input int unsigned base_hz, input rate_t r);
    int unsigned f2;
    int unsigned d;
    f2 = rate_x2(r);
    if (f2 == 0) return 1;
    d = (2 * base_hz) / f2;
    if (d == 0) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/s2w_cfg_regs.sv
module s2w_cfg_regs
  import s2w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_pm,
  input  logic [1:0] cfg_dr,
  input  logic       slp_wr,
  input  logic [1:0] slp_val,
  input  logic       irq_evt,
  output logic [2:0] pm_q,
  output logic [1:0] dr_q,
  output logic [1:0] slp_q
);

  logic wake_hit;
  assign wake_hit = (slp_q == SLP_ARM) && irq_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_q <= 3'b000;
      dr_q <= 2'b00;
    end else if (cfg_wr) begin
      pm_q <= cfg_pm;
      dr_q <= cfg_dr;
    end
  end

  // an explicit write takes priority over the automatic wake update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slp_q <= SLP_OFF;
    end else if (slp_wr) begin
      slp_q <= slp_val;
    end else if (wake_hit) begin
      slp_q <= SLP_WOKE;
    end
  end

endmodule

// File: rtl/s2w_mode_dec.sv
module s2w_mode_dec
  import s2w_pkg::*;
(
  input  logic [2:0] pm,
  input  logic [1:0] dr,
  input  logic [1:0] slp,
  output rate_t      rate_idx,
  output mode_e      mode
);

  rate_t lp_idx;
  logic  lp_valid;
  rate_t full_idx;

  always_comb begin
    lp_valid = 1'b1;
    case (pm)
      3'b010:  lp_idx = RT_LP_MIN;
      3'b011:  lp_idx = RT_LP_MIN + rate_t'(1);
      3'b100:  lp_idx = RT_LP_MIN + rate_t'(2);
      3'b101:  lp_idx = RT_LP_MIN + rate_t'(3);
      3'b110:  lp_idx = RT_LP_MIN + rate_t'(4);
      default: begin
        lp_idx   = RT_OFF;
        lp_valid = 1'b0;
      end
    endcase
  end

  assign full_idx = RT_FULL0 + rate_t'(dr);

  always_comb begin
    case (slp)
      SLP_ARM: begin
        mode     = MD_ARMED;
        rate_idx = lp_valid ? lp_idx : RT_LP_MIN;
      end
      SLP_WOKE: begin
        mode     = MD_FULL;
        rate_idx = full_idx;
      end
      default: begin
        // SLP_OFF and the reserved SLP_RSVD: power-mode field decides
        if (pm == 3'b001) begin
          mode     = MD_FULL;
          rate_idx = full_idx;
        end else if (lp_valid) begin
          mode     = MD_LOWPWR;
          rate_idx = lp_idx;
        end else begin
          mode     = MD_DOWN;
          rate_idx = RT_OFF;
        end
      end
    endcase
  end

endmodule

// File: rtl/s2w_tick_div.sv
module s2w_tick_div
  import s2w_pkg::*;
#(
  parameter int unsigned BASE_HZ = 100000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_t rate_idx,
  output logic  tick
);

  localparam int CNT_W = $clog2(2 * BASE_HZ + 1);

  logic [CNT_W-1:0] reload_tab [RATE_SLOTS];
  logic [CNT_W-1:0] cnt;
  rate_t            idx_q;

  for (genvar i = 0; i < RATE_SLOTS; i++) begin : g_reload
    assign reload_tab[i] = CNT_W'(rate_div(BASE_HZ, rate_t'(i)) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= RT_OFF;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (rate_idx != idx_q) begin
      idx_q <= rate_idx;
      cnt   <= reload_tab[rate_idx];
      tick  <= 1'b0;
    end else if (idx_q == RT_OFF) begin
      tick  <= 1'b0;
    end else if (cnt == '0) begin
      cnt   <= reload_tab[idx_q];
      tick  <= 1'b1;
    end else begin
      cnt   <= cnt - 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/s2w_rate_ctrl.sv
module s2w_rate_ctrl
  import s2w_pkg::*;
#(
  parameter int unsigned BASE_HZ = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_pm,
  input  logic [1:0] cfg_dr,
  input  logic       slp_wr,
  input  logic [1:0] slp_val,
  input  logic       irq_evt,
  output logic       sample_tick,
  output logic [2:0] pm_q,
  output logic [1:0] dr_q,
  output logic [1:0] slp_q,
  output logic [1:0] mode_o,
  output logic       pwr_down
);

  rate_t rate_idx;
  mode_e mode;

  s2w_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_pm  (cfg_pm),
    .cfg_dr  (cfg_dr),
    .slp_wr  (slp_wr),
    .slp_val (slp_val),
    .irq_evt (irq_evt),
    .pm_q    (pm_q),
    .dr_q    (dr_q),
    .slp_q   (slp_q)
  );

  s2w_mode_dec u_dec (
    .pm       (pm_q),
    .dr       (dr_q),
    .slp      (slp_q),
    .rate_idx (rate_idx),
    .mode     (mode)
  );

  s2w_tick_div #(.BASE_HZ(BASE_HZ)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_idx (rate_idx),
    .tick     (sample_tick)
  );

  assign mode_o   = mode;
  assign pwr_down = (mode == MD_DOWN);

endmodule

// File: rtl/s2w_rate_ctrl_chk.sv
module s2w_rate_ctrl_chk
  import s2w_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       slp_wr,
  input logic [1:0] slp_val,
  input logic       irq_evt,
  input logic       sample_tick,
  input logic [2:0] pm_q,
  input logic [1:0] slp_q,
  input logic [1:0] mode_o,
  input logic       pwr_down,
  input rate_t      rate_idx
);

  assert_quiet_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && $past(pwr_down)) |-> !sample_tick);

  assert_armed_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q == SLP_ARM) |-> (mode_o == 2'b11 && !pwr_down));

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q == SLP_ARM && irq_evt && !slp_wr) |=> (slp_q == SLP_WOKE));

  assert_pm_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q == SLP_ARM && irq_evt && !cfg_wr) |=> $stable(pm_q));

  assert_no_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q != SLP_ARM && !slp_wr) |=> $stable(slp_q));

  assert_woke_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q == SLP_WOKE) |-> (mode_o == 2'b01 && !pwr_down));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_idx) |=> !sample_tick);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slp_wr |=> (slp_q == $past(slp_val)));

endmodule

bind s2w_rate_ctrl s2w_rate_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .slp_wr      (slp_wr),
  .slp_val     (slp_val),
  .irq_evt     (irq_evt),
  .sample_tick (sample_tick),
  .pm_q        (pm_q),
  .slp_q       (slp_q),
  .mode_o      (mode_o),
  .pwr_down    (pwr_down),
  .rate_idx    (rate_idx)
);

// File: tb/tb_s2w_rate_ctrl.sv
`timescale 1ns/1ps
module tb_s2w_rate_ctrl;

  localparam int unsigned BASE = 2000;
  localparam int NOTICK_WAIT = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_pm = 3'b000;
  logic [1:0] cfg_dr = 2'b00;
  logic       slp_wr = 1'b0;
  logic [1:0] slp_val = 2'b00;
  logic       irq_evt = 1'b0;
  logic       sample_tick;
  logic [2:0] pm_q;
  logic [1:0] dr_q;
  logic [1:0] slp_q;
  logic [1:0] mode_o;
  logic       pwr_down;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  s2w_rate_ctrl #(.BASE_HZ(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pm(cfg_pm), .cfg_dr(cfg_dr),
    .slp_wr(slp_wr), .slp_val(slp_val), .irq_evt(irq_evt),
    .sample_tick(sample_tick), .pm_q(pm_q), .dr_q(dr_q), .slp_q(slp_q),
    .mode_o(mode_o), .pwr_down(pwr_down)
  );

  typedef struct packed {
    logic [2:0]  pm;
    logic [1:0]  dr;
    logic [1:0]  slp;
    logic [15:0] per;
    logic [1:0]  md;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  // periods at BASE=2000: 0.5Hz 4000, 1Hz 2000, 2Hz 1000, 5Hz 400, 10Hz 200,
  // 50Hz 40, 100Hz 20, 400Hz 5, 1000Hz 2; 0 = no strobe
  localparam vec_t VECS [NV] = '{
    '{3'b001, 2'b00, 2'b00, 16'd40,   2'b01, 8'd2},
    '{3'b001, 2'b01, 2'b00, 16'd20,   2'b01, 8'd2},
    '{3'b001, 2'b10, 2'b00, 16'd5,    2'b01, 8'd2},
    '{3'b001, 2'b11, 2'b00, 16'd2,    2'b01, 8'd2},
    '{3'b010, 2'b00, 2'b00, 16'd4000, 2'b10, 8'd3},
    '{3'b011, 2'b00, 2'b00, 16'd2000, 2'b10, 8'd3},
    '{3'b100, 2'b00, 2'b00, 16'd1000, 2'b10, 8'd3},
    '{3'b101, 2'b00, 2'b00, 16'd400,  2'b10, 8'd3},
    '{3'b110, 2'b00, 2'b00, 16'd200,  2'b10, 8'd3},
    '{3'b000, 2'b11, 2'b00, 16'd0,    2'b00, 8'd4},
    '{3'b111, 2'b11, 2'b00, 16'd0,    2'b00, 8'd4},
    '{3'b100, 2'b01, 2'b11, 16'd1000, 2'b11, 8'd5},
    '{3'b000, 2'b01, 2'b11, 16'd4000, 2'b11, 8'd5},
    '{3'b000, 2'b10, 2'b01, 16'd5,    2'b01, 8'd8},
    '{3'b110, 2'b11, 2'b01, 16'd2,    2'b01, 8'd8},
    '{3'b101, 2'b00, 2'b10, 16'd400,  2'b10, 8'd9},
    '{3'b000, 2'b00, 2'b10, 16'd0,    2'b00, 8'd9}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] pm, input logic [1:0] dr);
    cfg_pm = pm; cfg_dr = dr; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic write_slp(input logic [1:0] v);
    slp_val = v; slp_wr = 1'b1;
    @(negedge clk);
    slp_wr = 1'b0;
  endtask

  // cycles between two consecutive strobes, 0 when none appears
  task automatic measure(output int per);
    int n;
    per = 0;
    n = 0;
    while (!sample_tick && n < NOTICK_WAIT) begin @(negedge clk); n++; end
    if (sample_tick) begin
      @(negedge clk);
      n = 1;
      while (!sample_tick && n < NOTICK_WAIT) begin @(negedge clk); n++; end
      per = sample_tick ? n : 0;
    end
  endtask

  initial begin
    #(1520000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int per;
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pm_q == 3'b000 && dr_q == 2'b00 && slp_q == 2'b00, "R1 fields", {pm_q, dr_q, slp_q}, 0);
    check(mode_o == 2'b00 && pwr_down, "R1 mode", {mode_o, pwr_down}, 1);
    ticks = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (sample_tick) ticks++; end
    check(ticks == 0, "R1 no strobe", ticks, 0);

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      cfg_pm = VECS[v].pm; cfg_dr = VECS[v].dr; cfg_wr = 1'b1;
      slp_val = VECS[v].slp; slp_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; slp_wr = 1'b0;
      @(negedge clk);
      check(mode_o == VECS[v].md, $sformatf("R%0d mode vec%0d", VECS[v].rq, v), mode_o, VECS[v].md);
      check(pwr_down == (VECS[v].md == 2'b00), $sformatf("R%0d pwr_down vec%0d", VECS[v].rq, v),
            pwr_down, VECS[v].md == 2'b00);
      measure(per);
      check(per == int'(VECS[v].per), $sformatf("R%0d period vec%0d", VECS[v].rq, v), per, VECS[v].per);
    end

    // R6: wake from armed, pm untouched, full rate afterwards
    write_cfg(3'b011, 2'b11);
    write_slp(2'b11);
    irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0;
    check(slp_q == 2'b01, "R6 slp after event", slp_q, 1);
    check(pm_q == 3'b011, "R6 pm kept", pm_q, 3);
    check(mode_o == 2'b01, "R6 mode", mode_o, 1);
    @(negedge clk);
    measure(per);
    check(per == 2, "R6 period", per, 2);

    // R12: re-arm, then clear
    write_slp(2'b11);
    @(negedge clk);
    check(mode_o == 2'b11, "R12 re-armed mode", mode_o, 3);
    measure(per);
    check(per == 2000, "R12 re-armed period", per, 2000);
    write_slp(2'b00);
    @(negedge clk);
    check(mode_o == 2'b10, "R12 cleared mode", mode_o, 2);

    // R7: event ignored when not armed
    write_cfg(3'b001, 2'b01);
    irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0;
    @(negedge clk);
    check(slp_q == 2'b00, "R7 slp unchanged", slp_q, 0);
    check(mode_o == 2'b01, "R7 mode unchanged", mode_o, 1);
    write_slp(2'b10);
    irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0;
    check(slp_q == 2'b10, "R7 reserved code kept", slp_q, 2);
    write_slp(2'b00);

    // R11: write on the same edge as an event
    write_slp(2'b11);
    slp_val = 2'b00; slp_wr = 1'b1; irq_evt = 1'b1;
    @(negedge clk);
    slp_wr = 1'b0; irq_evt = 1'b0;
    check(slp_q == 2'b00, "R11 write wins", slp_q, 0);

    // R10: divider restart after rate change (50 Hz -> 400 Hz, D=5)
    write_cfg(3'b001, 2'b00);
    repeat (3) @(negedge clk);
    cfg_pm = 3'b001; cfg_dr = 2'b10; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    ticks = 0;
    for (int k = 2; k <= 6; k++) begin @(negedge clk); if (sample_tick) ticks++; end
    check(ticks == 0, "R10 quiet window", ticks, 0);
    @(negedge clk);
    check(sample_tick == 1'b1, "R10 first strobe", sample_tick, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule